// File: doc/BRIEF.md
# Encoder Pulse-Count Speed Meter

This block turns the pulse train from a motor shaft encoder into a small speed number that a control loop can use directly. A divide-down counter running from the fast system clock opens a measurement window of fixed length. During that window the block counts the rising edges of the encoder signal, after the signal has been brought into the clock domain by a two-flop synchronizer. When the window closes, the count is multiplied by a fixed-point scale factor, rounded, clamped and registered. A one-cycle strobe marks each new value.

With the default settings the clock runs at 100 MHz, the encoder gives 512 pulses per revolution and the window lasts 2 ms, so 500 measurements are made each second. The output equals the shaft speed in RPM divided by ten. One pulse per window is worth 375/64 (about 5.86) output units. The value is limited to the range 0 to 86. The scale factor is computed from the parameters when the design is elaborated. A smaller clock frequency and a shorter window with the same ratio therefore give exactly the same conversion.

Top module: `enc_speed_meter`

## Requirements
- R1: While reset is high and in the first cycle after it, `speed_rpm10` is 0 and `speed_valid` is 0.
- R2: `speed_valid` is high for exactly one cycle, and it repeats every GATE_CYCLES clock cycles.
- R3: Only low-to-high transitions of `enc_in` are counted. An input held high for most of a window adds exactly one count.
- R4: The reported value is (N·S + 2^(F−1)) >> F, where N is the edge count of the window just closed, F = 8, and S = round(60·CLK_HZ·2^F / (PULSES_PER_REV·GATE_CYCLES·10)). S is 1500 for the default ratio of clock to window.
- R5: Any result above 86 is reported as 86.
- R6: The count restarts at zero in every window. A window with no rising edges reports 0, even right after a window with many edges.
- R7: `speed_rpm10` changes only in a cycle where `speed_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_in | input | 1 | Encoder pulse line, asynchronous to clk |
| speed_rpm10 | output | 7 | Shaft speed in RPM/10, saturated |
| speed_valid | output | 1 | One-cycle strobe when a new speed value is loaded |

## Verification
A fault in the window timer shows up as a strobe period different from GATE_CYCLES, and it is visible at the first or second strobe after reset. A counter that does not clear, or that counts levels instead of edges, gives a wrong value at the very next strobe after a burst or a held-high window. Faults in the scaling or the clamp are found by sweeping the edge count of each window from 0 through 45. That sweep covers every rounding step and the saturation point at 15 edges, and each value is compared one window after its stimulus.

// File: rtl/spdm_pkg.sv
package spdm_pkg;

    localparam int FRAC_BITS = 8;
    localparam int SCALE_W   = 16;

    typedef struct packed {
        logic [6:0] value;
        logic       strobe;
    } speed_sample_t;

    // Rounded fixed-point factor from pulses per window to RPM/10.
    function automatic longint unsigned calc_scale(
        input longint unsigned clk_hz,
        input longint unsigned ppr,
        input longint unsigned gate_cycles
    );
        longint unsigned num;
        longint unsigned den;
        num = (60 * clk_hz) << FRAC_BITS;
        den = ppr * gate_cycles * 10;
        return (num + den / 2) / den;
    endfunction

endpackage

// File: rtl/spdm_gate_timer.sv
module spdm_gate_timer #(
    parameter int GATE_CYCLES = 200000
) (
    input  logic clk,
    input  logic rst,
    output logic gate_end
);
    localparam int TW = $clog2(GATE_CYCLES);

    logic [TW-1:0] tcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            tcnt <= '0;
        end else if (tcnt == TW'(GATE_CYCLES - 1)) begin
            tcnt <= '0;
        end else begin
            tcnt <= tcnt + 1'b1;
        end
    end

    assign gate_end = (tcnt == TW'(GATE_CYCLES - 1));

    AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (rst)
        tcnt < TW'(GATE_CYCLES)) else $error("timer out of range"); // R2
    AST_GATE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        gate_end |=> !gate_end) else $error("gate_end repeated"); // R2

endmodule

// File: rtl/spdm_edge_sync.sv
module spdm_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    logic [SYNC_STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain <= {chain[SYNC_STAGES-1:0], async_in};
        end
    end

    assign rise = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];

    AST_RISE_SPACED: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise) else $error("back-to-back rise"); // R3

endmodule

// File: rtl/spdm_pulse_counter.sv
module spdm_pulse_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rise,
    input  logic             gate_end,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (gate_end) begin
            count <= {{(CNT_W-1){1'b0}}, rise};
        end else if (rise && count != CNT_MAX) begin
            count <= count + 1'b1;
        end
    end

    AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (rst)
        gate_end |=> count <= CNT_W'(1)) else $error("count carried over"); // R6

endmodule

// File: rtl/spdm_scaler.sv
module spdm_scaler
    import spdm_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int SCALE  = 1500,
    parameter int OUT_MAX = 86
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] count,
    output speed_sample_t    sample
);
    localparam int PW = CNT_W + SCALE_W;
    localparam logic [PW-1:0] HALF = PW'(1) << (FRAC_BITS - 1);

    logic [PW-1:0] product;
    logic [PW-1:0] rounded;
    logic [6:0]    clamped;

    always_comb begin
        product = PW'(count) * PW'(SCALE);
        rounded = (product + HALF) >> FRAC_BITS;
        clamped = (rounded > PW'(OUT_MAX)) ? 7'(OUT_MAX) : rounded[6:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sample <= '0;
        end else begin
            sample.strobe <= load;
            if (load) begin
                sample.value <= clamped;
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        sample.value <= 7'(OUT_MAX)) else $error("speed above limit"); // R5
    AST_HOLD_VALUE: assert property (@(posedge clk) disable iff (rst)
        !sample.strobe |-> $stable(sample.value)) else $error("value moved"); // R7

endmodule

// File: rtl/enc_speed_meter.sv
module enc_speed_meter
    import spdm_pkg::*;
#(
    parameter int CLK_HZ         = 100_000_000,
    parameter int PULSES_PER_REV = 512,
    parameter int GATE_CYCLES    = 200_000,
    parameter int CNT_W          = 16,
    parameter int OUT_MAX        = 86
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       enc_in,
    output logic [6:0] speed_rpm10,
    output logic       speed_valid
);
    localparam int SCALE = int'(calc_scale(longint'(CLK_HZ),
                                           longint'(PULSES_PER_REV),
                                           longint'(GATE_CYCLES)));

    logic             gate_end;
    logic             rise;
    logic [CNT_W-1:0] count;
    speed_sample_t    sample;

    spdm_gate_timer #(.GATE_CYCLES(GATE_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .gate_end(gate_end)
    );

    spdm_edge_sync #(.SYNC_STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .async_in(enc_in), .rise(rise)
    );

    spdm_pulse_counter #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst(rst), .rise(rise), .gate_end(gate_end), .count(count)
    );

    spdm_scaler #(.CNT_W(CNT_W), .SCALE(SCALE), .OUT_MAX(OUT_MAX)) u_scale (
        .clk(clk), .rst(rst), .load(gate_end), .count(count), .sample(sample)
    );

    assign speed_rpm10 = sample.value;
    assign speed_valid = sample.strobe;

    AST_VALID_AFTER_GATE: assert property (@(posedge clk) disable iff (rst)
        gate_end |=> speed_valid) else $error("strobe missing"); // R2

endmodule

// File: tb/tb_enc_speed_meter.sv
module tb_enc_speed_meter;
    localparam int GATE = 200;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enc_in = 1'b0;
    logic [6:0] speed_rpm10;
    logic       speed_valid;

    int n_cmp = 0;
    int n_bad = 0;
    int gap;
    bit hold_ok;
    bit timed_out = 1'b0;

    always #5 clk = ~clk;

    enc_speed_meter #(
        .CLK_HZ(100_000), .PULSES_PER_REV(512), .GATE_CYCLES(GATE)
    ) dut (
        .clk(clk), .rst(rst), .enc_in(enc_in),
        .speed_rpm10(speed_rpm10), .speed_valid(speed_valid)
    );

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int expect_val(input int n);
        int v;
        v = (n * 1500 + 128) >>> 8;
        return (v > 86) ? 86 : v;
    endfunction

    // Waits for the next strobe; records the gap and whether the value held.
    task automatic wait_valid();
        logic [6:0] start;
        start = speed_rpm10;
        gap = 0;
        hold_ok = 1'b1;
        forever begin
            @(negedge clk);
            gap++;
            if (speed_valid) break;
            if (speed_rpm10 !== start) hold_ok = 1'b0;
            if (gap > 4 * GATE) begin
                timed_out = 1'b1;
                break;
            end
        end
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            enc_in = 1'b1;
            repeat (2) @(negedge clk);
            enc_in = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 speed in reset", speed_rpm10, 0);
        check("R1 valid in reset", speed_valid, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 speed after reset", speed_rpm10, 0);
        check("R1 valid after reset", speed_valid, 0);

        wait_valid();
        check("R6 idle window", speed_rpm10, 0);
        wait_valid();
        check("R2 strobe period", gap, GATE);
        @(negedge clk);
        check("R2 strobe width", speed_valid, 0);
        wait_valid();

        // R4/R5 sweep of edge counts per window
        for (int n = 0; n <= 45; n++) begin
            pulses(n);
            wait_valid();
            check($sformatf("R4 R5 count %0d", n), speed_rpm10, expect_val(n));
            check("R7 value held between strobes", int'(hold_ok), 1);
            if (timed_out) break;
        end

        // R6 empty window directly after a large burst
        pulses(40);
        wait_valid();
        check("R5 burst saturates", speed_rpm10, 86);
        wait_valid();
        check("R6 no carry-over", speed_rpm10, 0);
        check("R2 period in sweep", gap, GATE);

        // R3 level held high counts once
        enc_in = 1'b1;
        repeat (150) @(negedge clk);
        enc_in = 1'b0;
        wait_valid();
        check("R3 held level", speed_rpm10, expect_val(1));

        if (timed_out) check("watchdog", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150_000) @(posedge clk);
        n_bad++;
        n_cmp++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule